// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block collects 32×N level-sensitive interrupt lines and produces one interrupt output for each of several CPUs. N is the number of 32-line groups (2 or 4). Every CPU owns a private register bank on a simple 32-bit memory-mapped read/write bus. Each bank holds its own copy of the enable words and a read-only view of the raw line levels. A CPU's output rises when any raw line that is high is also enabled in that CPU's bank.

A bank is 2×N consecutive 32-bit words, and the banks are packed back to back with a stride of 8×N bytes. In each bank the N enable words come first and the N status words follow. Inside each half the word order is reversed, so the lowest-addressed word covers the highest-numbered lines. Software reads the status words, ANDs them with the enable words and services the sources it finds. The output is level-based, so it stays up for as long as an enabled line stays high.

Top module: `lvl_irq_agg`

## Requirements
- R1: After reset every enable bit is zero, every irq_out bit is low and rd_valid is low.
- R2: Word address w (byte address divided by 4) selects bank b = w / (2N) and offset o = w mod (2N). Bank b belongs to CPU b. Offsets 0..N-1 are enable words and offsets N..2N-1 are status words.
- R3: Word order is reversed inside each half. Enable offset o and status offset N+o both cover lines 32×(N-1-o) up to 32×(N-1-o)+31, with bit j of the word mapping to line 32×(N-1-o)+j.
- R4: A write to an enable offset replaces all 32 bits of that enable word, and a later read of the same offset returns the written value.
- R5: A read of a status offset returns the current levels of the raw lines it covers. A write to a status offset changes no enable word.
- R6: irq_out[k] equals the OR of (lines AND enable) over all N words of CPU k, registered once. It changes one clock after the lines or the enable word change.
- R7: The enable words of different CPUs are independent. A write to CPU k's bank alters no other CPU's enables or output.
- R8: A read of a word address at or beyond NUM_CPUS×2N returns zero, and a write to such an address has no effect.
- R9: rd_valid is high for exactly the one cycle after a cycle with req high and we low. It stays low after write cycles and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32*NUM_WORDS | Raw level interrupt lines; bit i is line i |
| req | input | 1 | Bus access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address; the two lowest bits are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High the cycle after a read request |
| irq_out | output | NUM_CPUS | One level interrupt output per CPU |

## Verification
The bench sweeps every word address of the bus space after loading distinct enable patterns and line patterns. This catches three kinds of fault: a decoder that ignores the word reversal, mixes up the enable and status halves, or aliases out-of-range addresses back onto a bank. Each of these would return an enable pattern or a line group at the wrong offset, or a nonzero value past the last bank. Single enable bits are walked through every CPU and word at the edge bit positions 0 and 31. This exposes outputs wired to the wrong CPU, a missing AND with the enable, and an enable that leaks across CPUs. Writes to status and out-of-range offsets are followed by a full readback sweep, which shows any write that went through. Output timing is sampled exactly one edge after each change, so an extra or missing flop is caught.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int LINES_PER_WORD = 32;
  localparam int BUS_W          = 32;

  // width helper that never returns zero
  function automatic int safe_clog2(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import lvl_irq_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic                                wr_i,
  output logic                                hit_o,
  output logic                                is_status_o,
  output logic [safe_clog2(NUM_CPUS)-1:0]     cpu_o,
  output logic [safe_clog2(NUM_WORDS)-1:0]    word_o,
  output logic [NUM_CPUS-1:0]                 ena_wr_o
);
  localparam int OFF_W  = $clog2(2 * NUM_WORDS);
  localparam int WADR_W = ADDR_W - 2;
  localparam int CPU_W  = safe_clog2(NUM_CPUS);
  localparam int WRD_W  = safe_clog2(NUM_WORDS);

  logic [WADR_W-1:0] waddr;
  logic [OFF_W-1:0]  offset;
  logic [WADR_W-1:0] bank;
  logic [1:0]        unused_lsb;

  assign unused_lsb = addr_i[1:0];
  assign waddr      = addr_i[ADDR_W-1:2];
  assign offset     = waddr[OFF_W-1:0];
  assign bank       = waddr >> OFF_W;

  assign hit_o       = (32'(bank) < 32'(NUM_CPUS));
  assign is_status_o = offset[OFF_W-1];
  assign cpu_o       = bank[CPU_W-1:0];
  // reversed order: lowest offset in each half maps to the highest word
  assign word_o      = WRD_W'(NUM_WORDS - 1) - WRD_W'(offset[OFF_W-2:0]);

  for (genvar k = 0; k < NUM_CPUS; k++) begin : g_sel
    assign ena_wr_o[k] = wr_i && hit_o && !is_status_o && (32'(bank) == k);
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ena_wr_o)); // R7
  AST_MISS_NO_SEL: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (ena_wr_o == '0)); // R8
  AST_STATUS_NO_SEL: assert property (@(posedge clk) disable iff (rst)
    (hit_o && is_status_o) |-> (ena_wr_o == '0)); // R5
endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
  import lvl_irq_pkg::*;
#(
  parameter int NUM_WORDS = 2
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     wr_i,
  input  logic [safe_clog2(NUM_WORDS)-1:0]         word_i,
  input  logic [BUS_W-1:0]                         wdata_i,
  input  logic [LINES_PER_WORD*NUM_WORDS-1:0]      lines_i,
  output logic [LINES_PER_WORD*NUM_WORDS-1:0]      ena_o,
  output logic                                     irq_o
);
  localparam int TOTAL = LINES_PER_WORD * NUM_WORDS;

  logic [NUM_WORDS-1:0][LINES_PER_WORD-1:0] ena_q;
  logic [TOTAL-1:0]                         pending;
  logic                                     irq_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        ena_q[w] <= '0;
      end else if (wr_i && (32'(word_i) == w)) begin
        ena_q[w] <= wdata_i;
      end
    end
  end

  assign ena_o   = ena_q;
  assign pending = lines_i & ena_o;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pending;
  end
  assign irq_o = irq_q;

  AST_ENA_HELD: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(ena_q)); // R4
  AST_IRQ_NEEDS_ENA: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|ena_q)); // R6
  AST_IRQ_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|lines_i)); // R6
endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg
  import lvl_irq_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [32*NUM_WORDS-1:0]         irq_lines,
  input  logic                            req,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [31:0]                     wdata,
  output logic [31:0]                     rdata,
  output logic                            rd_valid,
  output logic [NUM_CPUS-1:0]             irq_out
);
  localparam int CPU_W = safe_clog2(NUM_CPUS);
  localparam int WRD_W = safe_clog2(NUM_WORDS);
  localparam int TOTAL = LINES_PER_WORD * NUM_WORDS;

  logic                    hit, is_status;
  logic [CPU_W-1:0]        cpu_sel;
  logic [WRD_W-1:0]        word_sel;
  logic [NUM_CPUS-1:0]     ena_wr;
  logic [TOTAL-1:0]        ena_all [NUM_CPUS];
  logic [BUS_W-1:0]        rd_mux;
  logic [BUS_W-1:0]        rdata_q;
  logic                    rvalid_q;

  irq_addr_decode #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr),
    .wr_i       (req && we),
    .hit_o      (hit),
    .is_status_o(is_status),
    .cpu_o      (cpu_sel),
    .word_o     (word_sel),
    .ena_wr_o   (ena_wr)
  );

  for (genvar k = 0; k < NUM_CPUS; k++) begin : g_cpu
    irq_cpu_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_i   (ena_wr[k]),
      .word_i (word_sel),
      .wdata_i(wdata),
      .lines_i(irq_lines),
      .ena_o  (ena_all[k]),
      .irq_o  (irq_out[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      if (is_status) rd_mux = irq_lines[32'(word_sel)*LINES_PER_WORD +: LINES_PER_WORD];
      else           rd_mux = ena_all[cpu_sel][32'(word_sel)*LINES_PER_WORD +: LINES_PER_WORD];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req && !we;
      rdata_q  <= (req && !we) ? rd_mux : '0;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rvalid_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && !rd_valid)); // R1
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (req && !we) |=> rd_valid); // R9
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    !(req && !we) |=> !rd_valid); // R9
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req && !we && !hit) |=> (rdata == '0)); // R8
endmodule

// File: tb/lvl_irq_agg_tb.sv
`timescale 1ns/1ps
module lvl_irq_agg_tb_top;
  localparam int C  = 2;
  localparam int N  = 2;
  localparam int AW = 8;
  localparam int NADDR = 1 << (AW - 2);

  logic              clk = 1'b0;
  logic              rst;
  logic [32*N-1:0]   lines;
  logic              req, we;
  logic [AW-1:0]     addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic              rd_valid;
  logic [C-1:0]      irq_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] ena_m [C][N];

  always #4 clk = ~clk;

  lvl_irq_agg #(.NUM_CPUS(C), .NUM_WORDS(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .irq_lines(lines), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .irq_out(irq_out)
  );

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int w);
    int b, o;
    b = w / (2 * N);
    o = w % (2 * N);
    if (b >= C) return 32'h0;
    if (o < N)  return ena_m[b][N-1-o];
    return lines[(2*N-1-o)*32 +: 32];
  endfunction

  function automatic logic [C-1:0] exp_irq();
    logic [C-1:0] r = '0;
    for (int k = 0; k < C; k++)
      for (int w = 0; w < N; w++)
        if ((ena_m[k][w] & lines[w*32 +: 32]) != 0) r[k] = 1'b1;
    return r;
  endfunction

  task automatic bus_write(input int waddr, input logic [31:0] d);
    int b, o;
    @(negedge clk);
    req = 1; we = 1; addr = AW'(waddr * 4); wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    b = waddr / (2 * N);
    o = waddr % (2 * N);
    if (b < C && o < N) ena_m[b][N-1-o] = d;
  endtask

  task automatic bus_read(input int waddr, input string tag);
    @(negedge clk);
    req = 1; we = 0; addr = AW'(waddr * 4);
    @(posedge clk); #1;
    check({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
    check(tag, rdata, exp_read(waddr));
    @(negedge clk);
    req = 0;
    @(posedge clk); #1;
    check("R9 rd_valid drop", 32'(rd_valid), 32'd0);
  endtask

  task automatic sweep(input string tag);
    for (int w = 0; w < NADDR; w++) bus_read(w, tag);
  endtask

  task automatic irq_check(input string tag);
    @(posedge clk); #1;
    check(tag, 32'(irq_out), 32'(exp_irq()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < C; k++) for (int w = 0; w < N; w++) ena_m[k][w] = '0;
    rst = 1; req = 0; we = 0; addr = '0; wdata = '0;
    lines = {32*N{1'b1}};
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq_out reset", 32'(irq_out), 32'd0);
    check("R1 rd_valid reset", 32'(rd_valid), 32'd0);
    @(negedge clk); rst = 0;
    irq_check("R1 irq_out low with lines high");
    sweep("R1 R2 R3 R8 reset sweep");

    // R4 R3 R7: distinct patterns per cpu/word
    for (int k = 0; k < C; k++)
      for (int o = 0; o < N; o++)
        bus_write(k * 2 * N + o, 32'hA5000000 ^ (k << 16) ^ (o << 8) ^ 32'h3C);
    lines = 64'h0123_4567_89AB_CDEF;
    sweep("R2 R3 R4 R5 pattern sweep");

    // R5 status writes ignored, R8 out-of-range writes ignored
    for (int k = 0; k < C; k++)
      for (int o = N; o < 2 * N; o++) bus_write(k * 2 * N + o, 32'hFFFF_FFFF);
    for (int w = C * 2 * N; w < NADDR; w += 5) bus_write(w, 32'hDEAD_BEEF);
    lines = 64'hFEDC_BA98_7654_3210;
    sweep("R5 R8 after ignored writes");

    // R6 R7: walk single enable bits
    for (int k = 0; k < C; k++)
      for (int o = 0; o < 2 * C * N; o++) if (o < N) bus_write(k * 2 * N + o, 32'h0);
    for (int k = 0; k < C; k++) begin
      for (int wd = 0; wd < N; wd++) begin
        for (int bi = 0; bi < 32; bi += 31) begin
          bus_write(k * 2 * N + (N - 1 - wd), 32'h1 << bi);
          lines = '0;
          lines[wd*32 + bi] = 1'b1;
          irq_check("R6 R7 matching line");
          check("R7 only owner", 32'(irq_out), 32'(1 << k));
          lines = '0;
          lines[((wd*32 + bi) + 1) % (32*N)] = 1'b1;
          irq_check("R6 other line no irq");
          bus_write(k * 2 * N + (N - 1 - wd), 32'h0);
        end
      end
    end

    // R6 latency: output lags line change by one edge
    bus_write(0, 32'hFFFF_FFFF);
    @(negedge clk);
    lines = '0;
    lines[32*(N-1)] = 1'b1;
    #1;
    check("R6 not yet updated", 32'(irq_out), 32'd0);
    irq_check("R6 one-cycle latency");
    lines = '0;
    irq_check("R6 drops with line");

    // R9 write does not raise rd_valid
    @(negedge clk); req = 1; we = 1; addr = '0; wdata = 32'h1;
    @(posedge clk); #1;
    check("R9 no rd_valid on write", 32'(rd_valid), 32'd0);
    @(negedge clk); req = 0; we = 0;
    ena_m[0][N-1] = 32'h1;
    sweep("R4 final sweep");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule